// File: doc/BRIEF.md
# Stopwatch Control State Machine

This block sequences a two-button stopwatch. It takes single-cycle start and stop pulses and drives a time counter through two outputs: a level that lets the counter advance and a one-cycle pulse that sets the counter back to zero. The pulses come from edge detectors fed by debounced buttons, so each press arrives as exactly one active cycle.

The machine has three modes: idle, running and paused. Start leaves idle for running, and it also resumes from paused with the held count. Stop has two meanings. The first stop while running pauses the count. A second stop while paused clears the count and returns the machine to idle. Stop does nothing in idle, and start does nothing while running.

All state changes on the rising clock edge. An asynchronous active-low reset forces the machine to idle.

Top module: `sw_ctrl_fsm`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `run_en` and `clr_pulse` are both low and the machine is idle. This holds whatever the machine was doing before the reset.
- R2: In idle, a stop pulse on its own has no effect: both outputs stay low, and a later stop still raises no clear.
- R3: In idle, a start pulse sampled at a clock edge raises `run_en` right after that same edge.
- R4: While running, `run_en` stays high in every cycle that has no stop pulse, and a start pulse while running changes nothing.
- R5: While running, a stop pulse drops `run_en` right after the edge that samples it, without a clear, and the machine enters paused.
- R6: In paused, a start pulse with no stop raises `run_en` again right after the edge that samples it.
- R7: In paused, a stop pulse raises `clr_pulse` right after the edge that samples it, for exactly one cycle, and the machine returns to idle.
- R8: When start and stop arrive in the same cycle, start wins in idle, and stop wins in running and in paused.
- R9: `clr_pulse` and `run_en` are never high together. `clr_pulse` rises only after a stop pulse sampled in paused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start_pulse | input | 1 | One-cycle start request |
| stop_pulse | input | 1 | One-cycle stop request |
| run_en | output | 1 | High while the counter should advance |
| clr_pulse | output | 1 | One-cycle request to zero the counter |

## Verification
Idle and paused look the same at the ports, because both outputs are low in both modes. The bench therefore tells them apart by their reaction to a later stop pulse: a stop in paused raises a clear, and a stop in idle does not. The hardest case is the clear itself, because it needs a start, a pause and a second stop in that order. The vector table builds that order several times, once with start and stop arriving together, and the directed tests repeat the probe after a reset taken while running.

// File: rtl/sw_ctrl_fsm.sv
module sw_ctrl_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic start_pulse,
  input  logic stop_pulse,
  output logic run_en,
  output logic clr_pulse
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } st_t;

  st_t  state, nxt;
  logic clr_q;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (start_pulse) nxt = ST_RUN;
      ST_RUN:   if (stop_pulse)  nxt = ST_PAUSE;
      ST_PAUSE: if (stop_pulse)  nxt = ST_IDLE;
                else if (start_pulse) nxt = ST_RUN;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      clr_q <= 1'b0;
    end else begin
      state <= nxt;
      clr_q <= (state == ST_PAUSE) && stop_pulse;
    end
  end

  assign run_en    = (state == ST_RUN);
  assign clr_pulse = clr_q;

endmodule

// File: rtl/sw_ctrl_fsm_chk.sv
module sw_ctrl_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_pulse,
  input logic       stop_pulse,
  input logic       run_en,
  input logic       clr_pulse,
  input logic [1:0] st
);
  localparam logic [1:0] S_IDLE  = 2'd0;
  localparam logic [1:0] S_PAUSE = 2'd2;

  p_idle_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && stop_pulse && !start_pulse) |=> (!run_en && !clr_pulse));

  p_idle_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start_pulse) |=> run_en);

  p_run_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !stop_pulse) |=> run_en);

  p_run_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && stop_pulse) |=> (!run_en && !clr_pulse));

  p_pause_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAUSE && start_pulse && !stop_pulse) |=> run_en);

  p_pause_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAUSE && stop_pulse) |=> (clr_pulse && !run_en) ##1 !clr_pulse);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_pulse && run_en));

  p_clear_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_pulse) |-> $past(st == S_PAUSE && stop_pulse));

endmodule

bind sw_ctrl_fsm sw_ctrl_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
  .run_en(run_en), .clr_pulse(clr_pulse), .st(state)
);

// File: tb/sw_ctrl_fsm_tb.sv
module sw_ctrl_fsm_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_pulse = 1'b0;
  logic stop_pulse = 1'b0;
  logic run_en, clr_pulse;
  int checks = 0;
  int errors = 0;
  bit both_seen = 1'b0;

  always #10 clk = ~clk;

  sw_ctrl_fsm u_dut (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .run_en(run_en), .clr_pulse(clr_pulse)
  );

  // {start, stop, expected run_en, expected clr_pulse} after the sampling edge
  localparam int NV = 16;
  localparam logic [3:0] VEC [NV] = '{
    4'b0100,  // R2 stop in idle
    4'b0000,  // R2
    4'b1010,  // R3 start from idle
    4'b0010,  // R4 hold
    4'b1010,  // R4 start ignored
    4'b0100,  // R5 pause
    4'b0000,  // R5 held
    4'b1010,  // R6 resume
    4'b0100,  // R5 pause again
    4'b0101,  // R7 clear
    4'b0000,  // R7 clear lasts one cycle
    4'b0100,  // R7 back in idle, stop inert
    4'b1110,  // R8 idle: start wins
    4'b1100,  // R8 running: stop wins
    4'b1101,  // R8 paused: stop wins
    4'b0000   // R7 one cycle
  };
  localparam int VREQ [NV] = '{2,2,3,4,4,5,5,6,5,7,7,7,8,8,8,7};

  task automatic check(input string req, input logic got_run, input logic got_clr,
                       input logic exp_run, input logic exp_clr);
    checks++;
    if (got_run !== exp_run || got_clr !== exp_clr) begin
      errors++;
      $display("FAIL %s: run_en=%b clr_pulse=%b expected run_en=%b clr_pulse=%b",
               req, got_run, got_clr, exp_run, exp_clr);
    end
  endtask

  task automatic step(input logic s, input logic p);
    @(negedge clk);
    start_pulse = s;
    stop_pulse  = p;
    @(posedge clk);
    #5;
    start_pulse = 1'b0;
    stop_pulse  = 1'b0;
  endtask

  always @(negedge clk) if (rst_n && run_en && clr_pulse) both_seen = 1'b1;

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run_en=%b clr_pulse=%b expected finish", run_en, clr_pulse);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1 in reset", run_en, clr_pulse, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    check("R1 after release", run_en, clr_pulse, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][3], VEC[i][2]);
      check($sformatf("R%0d vector %0d", VREQ[i], i), run_en, clr_pulse, VEC[i][1], VEC[i][0]);
    end

    step(1'b1, 1'b0);
    check("R3 start", run_en, clr_pulse, 1'b1, 1'b0);
    repeat (5) begin
      step(1'b0, 1'b0);
      check("R4 long run", run_en, clr_pulse, 1'b1, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    check("R1 reset while running", run_en, clr_pulse, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b1);
    check("R1 idle after reset, stop inert", run_en, clr_pulse, 1'b0, 1'b0);
    step(1'b0, 1'b1);
    check("R2 repeated stop in idle", run_en, clr_pulse, 1'b0, 1'b0);

    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check("R5 pause held several cycles", run_en, clr_pulse, 1'b0, 1'b0);
    step(1'b1, 1'b0);
    check("R6 late resume", run_en, clr_pulse, 1'b1, 1'b0);

    checks++;
    if (both_seen) begin
      errors++;
      $display("FAIL R9: run_en and clr_pulse both high seen=1 expected 0");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule